// File: doc/BRIEF.md
# Latched Second-Level Interrupt Aggregator

This block gathers thirty-two edge-type interrupt sources into one interrupt line for a parent controller. A rising edge on a source input latches a pending bit. The bit stays set until software clears it. A per-source disable mask gates each pending bit. The output is the registered OR of every pending bit whose mask bit is clear.

Software reaches the block through a plain 32-bit register port with address, write enable, write data, read enable and read data. The pending set and the mask each have three views: a read view, a write-one-to-set view and a write-one-to-clear view. Software therefore never needs a read-modify-write, and it can raise a pending bit directly, the same way a hardware edge does. Source n uses bit n of every register.

Top module: `irq_latch_agg`

## Requirements
- R1: After reset every pending bit is 0, every mask bit is 1 (all sources disabled) and `irq_o` is 0.
- R2: A rising edge on `src_i[n]`, found by comparing the input with its registered value from the previous cycle, sets pending bit n at the next clock edge. A level held high does not set the bit again once it is cleared.
- R3: A pending bit stays set after its source input returns low, until a clear write removes it.
- R4: A write to offset 0x08 clears every pending bit written as 1 and leaves bits written as 0 unchanged.
- R5: A write to offset 0x04 sets every pending bit written as 1 and leaves bits written as 0 unchanged.
- R6: A write to offset 0x10 sets the mask bits written as 1. A write to offset 0x14 clears the mask bits written as 1. Bits written as 0 are unchanged. A mask bit of 1 disables its source.
- R7: `irq_o` is a register. One clock after the pending and mask state is in place, it equals the OR over all bits of (pending AND NOT mask).
- R8: A masked source still records its edges as pending. Clearing its mask bit afterwards raises `irq_o` while the bit is still pending.
- R9: If a source edge arrives in the same cycle as a clear write to that bit, the bit stays set.
- R10: With `rd_en` high, `rd_data` returns the pending bits at offsets 0x00, 0x04 and 0x08, and the mask at offsets 0x0C, 0x10 and 0x14. It returns 0 at any other offset or when `rd_en` is low. The read path is combinational.
- R11: Writes to the read-only offsets 0x00 and 0x0C, and writes to any unmapped offset, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Edge-type interrupt sources, bit n is source n |
| addr | input | 8 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe, taken at the clock edge |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read enable |
| rd_data | output | 32 | Read data, combinational from addr and rd_en |
| irq_o | output | 1 | Registered interrupt to the parent controller |

## Verification
Writes and source edges take effect at the clock edge that samples them. The bench drives them just after a falling edge and reads the registers back at the next falling edge, because the read path has no register. `irq_o` depends on the updated state through one more register, so it is due one full clock later, and each output check waits that extra cycle before sampling. The concurrent edge-and-clear case drives the source rise and the clear write in the same cycle. It then checks the pending bit at the next falling edge.

// File: rtl/irq_latch_agg.sv
module irq_latch_agg #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src_i,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          irq_o
);
  localparam logic [AW-1:0] OFS_PEND     = AW'(8'h00);
  localparam logic [AW-1:0] OFS_PEND_SET = AW'(8'h04);
  localparam logic [AW-1:0] OFS_PEND_CLR = AW'(8'h08);
  localparam logic [AW-1:0] OFS_MASK     = AW'(8'h0C);
  localparam logic [AW-1:0] OFS_MASK_SET = AW'(8'h10);
  localparam logic [AW-1:0] OFS_MASK_CLR = AW'(8'h14);

  logic [DW-1:0] src_q, pend, mask;
  logic [DW-1:0] rise, p_set, p_clr, m_set, m_clr, rview;

  assign rise  = src_i & ~src_q;
  assign p_set = (wr_en && addr == OFS_PEND_SET) ? wr_data : '0;
  assign p_clr = (wr_en && addr == OFS_PEND_CLR) ? wr_data : '0;
  assign m_set = (wr_en && addr == OFS_MASK_SET) ? wr_data : '0;
  assign m_clr = (wr_en && addr == OFS_MASK_CLR) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
      mask  <= '1;
      irq_o <= 1'b0;
    end else begin
      src_q <= src_i;
      pend  <= (pend & ~p_clr) | p_set | rise;
      mask  <= (mask | m_set) & ~m_clr;
      irq_o <= |(pend & ~mask);
    end
  end

  always_comb begin
    case (addr)
      OFS_PEND, OFS_PEND_SET, OFS_PEND_CLR: rview = pend;
      OFS_MASK, OFS_MASK_SET, OFS_MASK_CLR: rview = mask;
      default:                              rview = '0;
    endcase
  end

  assign rd_data = rd_en ? rview : '0;

  a_r2_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(rise)) == $past(rise)));

  a_r3_no_silent_drop: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~pend & ~$past(p_clr)) == '0));

  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_PEND_CLR) |=> ((pend & $past(wr_data & ~rise)) == '0));

  a_r5_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_PEND_SET) |=> ((pend & $past(wr_data)) == $past(wr_data)));

  a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MASK_SET) |=> ((mask & $past(wr_data)) == $past(wr_data)));

  a_r6_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MASK_CLR) |=> ((mask & $past(wr_data)) == '0));

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(pend) & ~$past(mask))));

  a_r11_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == OFS_MASK_SET || addr == OFS_MASK_CLR)) |=> $stable(mask));
endmodule

// File: tb/sim_irq_latch_agg.sv
`timescale 1ns/1ps
module sim_irq_latch_agg;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] src_i = '0, wr_data = '0, rd_data;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, irq_o;
  int          errors = 0, checks = 0;

  always #4 clk = ~clk;

  irq_latch_agg u0 (.clk, .rst_n, .src_i, .addr, .wr_en, .wr_data, .rd_en, .rd_data, .irq_o);

  // each vector: {offset, write data, expected pending, expected mask}
  localparam logic [103:0] VEC [10] = '{
    {8'h04, 32'h0000_00F0, 32'h0000_00F0, 32'hFFFF_FFFF},  // R5
    {8'h14, 32'h0000_0030, 32'h0000_00F0, 32'hFFFF_FFCF},  // R6
    {8'h08, 32'h0000_0010, 32'h0000_00E0, 32'hFFFF_FFCF},  // R4
    {8'h00, 32'hFFFF_FFFF, 32'h0000_00E0, 32'hFFFF_FFCF},  // R11
    {8'h0C, 32'h0000_0000, 32'h0000_00E0, 32'hFFFF_FFCF},  // R11
    {8'h10, 32'h0000_0020, 32'h0000_00E0, 32'hFFFF_FFEF},  // R6
    {8'h14, 32'h8000_0040, 32'h0000_00E0, 32'h7FFF_FFAF},  // R6
    {8'h04, 32'h8000_0000, 32'h8000_00E0, 32'h7FFF_FFAF},  // R5
    {8'h18, 32'hFFFF_FFFF, 32'h8000_00E0, 32'h7FFF_FFAF},  // R11
    {8'h08, 32'hFFFF_FFFF, 32'h0000_0000, 32'h7FFF_FFAF}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00, v); chk("R1 pending", v, 32'h0);
    rd(8'h0C, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    foreach (VEC[i]) begin
      wr(VEC[i][103:96], VEC[i][95:64]);
      rd(8'h00, v); chk("R4/R5/R11 pending vector", v, VEC[i][63:32]);
      rd(8'h0C, v); chk("R6/R11 mask vector", v, VEC[i][31:0]);
      @(negedge clk);
      chk("R7 irq vector", {31'b0, irq_o}, {31'b0, |(VEC[i][63:32] & ~VEC[i][31:0])});
    end

    // R10 read views and gating
    wr(8'h04, 32'h0000_0100);
    rd(8'h04, v); chk("R10 set view", v, 32'h0000_0100);
    rd(8'h08, v); chk("R10 clear view", v, 32'h0000_0100);
    rd(8'h10, v); chk("R10 mask set view", v, 32'h7FFF_FFAF);
    rd(8'h14, v); chk("R10 mask clear view", v, 32'h7FFF_FFAF);
    rd(8'h1C, v); chk("R10 unmapped", v, 32'h0);
    addr = 8'h00; #1 chk("R10 rd_en low", rd_data, 32'h0);
    wr(8'h08, 32'h0000_0100);

    // R2/R3 edge capture and latching; mask bit 3 cleared first
    wr(8'h14, 32'h0000_0008);
    src_i[3] = 1'b1;
    @(negedge clk);
    rd(8'h00, v); chk("R2 edge sets", v, 32'h0000_0008);
    @(negedge clk);
    chk("R7 irq after edge", {31'b0, irq_o}, 32'h1);
    src_i[3] = 1'b0;
    repeat (2) @(negedge clk);
    rd(8'h00, v); chk("R3 stays latched", v, 32'h0000_0008);
    src_i[3] = 1'b1;
    @(negedge clk);
    wr(8'h08, 32'h0000_0008);
    repeat (2) @(negedge clk);
    rd(8'h00, v); chk("R2 level no retrigger", v, 32'h0);
    chk("R7 irq drops", {31'b0, irq_o}, 32'h0);
    src_i[3] = 1'b0;

    // R8 masked source records, unmask raises irq (bit 5 masked)
    src_i[5] = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h00, v); chk("R8 masked still pending", v, 32'h0000_0020);
    chk("R8 masked no irq", {31'b0, irq_o}, 32'h0);
    src_i[5] = 1'b0;
    wr(8'h14, 32'h0000_0020);
    @(negedge clk);
    chk("R8 unmask raises irq", {31'b0, irq_o}, 32'h1);
    wr(8'h08, 32'h0000_0020);

    // R9 edge and clear in the same cycle
    @(negedge clk);
    addr = 8'h08; wr_data = 32'h0000_0080; wr_en = 1'b1; src_i[7] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(8'h00, v); chk("R9 edge beats clear", v, 32'h0000_0080);
    src_i[7] = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule